// File: doc/BRIEF.md
# Two-Dimensional Odd-Parity Grid Corrector

The block protects a 16-bit word by placing its bits in a 4x4 grid and adding odd parity in two directions. Each row gets one check bit and each column gets one. A corner bit covers the column check bits. The result is a 25-bit protected word. One input port serves both directions of the link. In encode mode the block takes a data word and returns the protected word. In decode mode it takes a received 25-bit word, recomputes every check, and does one of three things:

- It repairs a single flipped bit, whether that bit is data or check.
- It flags patterns it can see but cannot locate.
- It passes clean words through unchanged.

The block has no internal backpressure and accepts a word on every cycle. Results appear on registered outputs one cycle after the input is accepted. Each result carries a 2-bit status.

Codeword layout (bit indices of the 25-bit word):

| Bits | Contents |
|------|----------|
| [15:0] | Data. Grid cell (row r, column c) is bit r*4+c. |
| [19:16] | Row check bits. Row r uses bit 16+r. |
| [23:20] | Column check bits. Column c uses bit 20+c. |
| [24] | Corner bit. |

Top module: `grid_parity_corrector`

## Requirements
- R1: In encode mode (`mode_i`=0) the output word carries the input data unchanged in bits [15:0]. Bits [19:16] hold the row check bits, bits [23:20] hold the column check bits, and bit 24 holds the corner bit.
- R2: Parity is odd in every direction. Each row's four data bits plus its row check bit contain an odd number of ones. Each column's four data bits plus its column check bit contain an odd number of ones. The four column check bits plus the corner bit contain an odd number of ones.
- R3: In decode mode (`mode_i`=1), a word that satisfies every check gives status 00. The data and word outputs equal the input.
- R4: A single flipped data bit gives exactly one failing row and one failing column. The block inverts the bit at their intersection, returns the original data and word, and gives status 01.
- R5: A single flipped row check bit gives one failing row, no failing column and a passing corner check. The data passes unchanged, the check bit is repaired in the word output, and the status is 01.
- R6: A single flipped column check bit gives one failing column, no failing row and a failing corner check. The data passes unchanged, the check bit is repaired, and the status is 01.
- R7: A flipped corner bit alone, with all row and column checks passing, is repaired and gives status 01.
- R8: Any two flipped bits give status 10. This includes two errors in the same row, which fail two columns and no row. The data and word outputs equal the received word, with nothing inverted.
- R9: `in_ready_o` is always high. `out_valid_o` is high in the cycle after each cycle with `in_valid_i` high, and low otherwise. Reset clears `out_valid_o`.
- R10: Status code 11 never appears. Encode results always report status 00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input word present |
| in_ready_o | output | 1 | Always high; a word is accepted every cycle |
| mode_i | input | 1 | 0 = encode bits [15:0]; 1 = decode the full word |
| word_i | input | 25 | Data (encode) or received codeword (decode) |
| out_valid_o | output | 1 | Registered result valid |
| out_data_o | output | 16 | Data, corrected when possible |
| out_word_o | output | 25 | Encoded or repaired codeword |
| out_status_o | output | 2 | 00 clean, 01 corrected, 10 uncorrectable |

## Verification
A wrong row or column syndrome shows at the ports in the very next output. It appears either as a wrong status code or as a data bit inverted at the wrong intersection. Any error in the classification shows up when a single error and a double error are compared. Every single error must come back as the original codeword, and every double error must come back as the received word untouched. The bench mixes random data with zero, one or two injected flips at random positions. It also drives a directed case for each kind of check bit. This way a mislocated repair is caught on the cycle it is produced.

// File: rtl/gpc_pkg.sv
package gpc_pkg;
  typedef enum logic [1:0] {
    ST_CLEAN = 2'b00,
    ST_FIXED = 2'b01,
    ST_FATAL = 2'b10
  } gpc_status_e;
endpackage

// File: rtl/gpc_encoder.sv
module gpc_encoder #(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  localparam int DW = ROWS * COLS,
  localparam int CW = DW + ROWS + COLS + 1
) (
  input  logic [DW-1:0] data_i,
  output logic [CW-1:0] code_o
);
  logic [ROWS-1:0] row_par;
  logic [COLS-1:0] col_par;

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign row_par[r] = ~(^data_i[r*COLS +: COLS]);
  end

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [ROWS-1:0] col_bits;
    for (genvar r = 0; r < ROWS; r++) begin : g_bit
      assign col_bits[r] = data_i[r*COLS + c];
    end
    assign col_par[c] = ~(^col_bits);
  end

  assign code_o = {~(^col_par), col_par, row_par, data_i};
endmodule

// File: rtl/gpc_syndrome.sv
module gpc_syndrome #(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  localparam int DW = ROWS * COLS,
  localparam int CW = DW + ROWS + COLS + 1
) (
  input  logic [CW-1:0]   code_i,
  output logic [ROWS-1:0] row_fail_o,
  output logic [COLS-1:0] col_fail_o,
  output logic            corner_fail_o
);
  logic [DW-1:0]   data;
  logic [ROWS-1:0] row_par;
  logic [COLS-1:0] col_par;

  assign data    = code_i[DW-1:0];
  assign row_par = code_i[DW +: ROWS];
  assign col_par = code_i[DW+ROWS +: COLS];

  // An even count of ones in a line means that line's check failed.
  for (genvar r = 0; r < ROWS; r++) begin : g_row
    assign row_fail_o[r] = ~(^{data[r*COLS +: COLS], row_par[r]});
  end

  for (genvar c = 0; c < COLS; c++) begin : g_col
    logic [ROWS-1:0] col_bits;
    for (genvar r = 0; r < ROWS; r++) begin : g_bit
      assign col_bits[r] = data[r*COLS + c];
    end
    assign col_fail_o[c] = ~(^{col_bits, col_par[c]});
  end

  assign corner_fail_o = ~(^{col_par, code_i[CW-1]});
endmodule

// File: rtl/gpc_corrector.sv
module gpc_corrector
  import gpc_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  localparam int DW = ROWS * COLS,
  localparam int CW = DW + ROWS + COLS + 1
) (
  input  logic [CW-1:0]   code_i,
  input  logic [ROWS-1:0] row_fail_i,
  input  logic [COLS-1:0] col_fail_i,
  input  logic            corner_fail_i,
  output logic [CW-1:0]   code_o,
  output gpc_status_e     status_o
);
  logic one_row, one_col, no_row, no_col;
  logic fix_data, fix_row_par, fix_col_par, fix_corner;
  logic [CW-1:0] flip;

  assign one_row = ($countones(row_fail_i) == 1);
  assign one_col = ($countones(col_fail_i) == 1);
  assign no_row  = ~|row_fail_i;
  assign no_col  = ~|col_fail_i;

  // Each single-error class has its own signature; anything else is fatal.
  assign fix_data    = one_row & one_col & ~corner_fail_i;
  assign fix_row_par = one_row & no_col  & ~corner_fail_i;
  assign fix_col_par = no_row  & one_col &  corner_fail_i;
  assign fix_corner  = no_row  & no_col  &  corner_fail_i;

  for (genvar r = 0; r < ROWS; r++) begin : g_fr
    for (genvar c = 0; c < COLS; c++) begin : g_fc
      assign flip[r*COLS + c] = fix_data & row_fail_i[r] & col_fail_i[c];
    end
    assign flip[DW + r] = fix_row_par & row_fail_i[r];
  end
  for (genvar c = 0; c < COLS; c++) begin : g_fp
    assign flip[DW + ROWS + c] = fix_col_par & col_fail_i[c];
  end
  assign flip[CW-1] = fix_corner;

  assign code_o = code_i ^ flip;

  always_comb begin
    if (no_row && no_col && !corner_fail_i)                 status_o = ST_CLEAN;
    else if (fix_data || fix_row_par || fix_col_par || fix_corner) status_o = ST_FIXED;
    else                                                     status_o = ST_FATAL;
  end

  always_comb begin
    p_single_flip_r4: assert ($onehot0(flip));
    p_fix_has_flip_r5: assert ((status_o == ST_FIXED) == (|flip));
  end
endmodule

// File: rtl/grid_parity_corrector.sv
module grid_parity_corrector
  import gpc_pkg::*;
#(
  parameter int ROWS = 4,
  parameter int COLS = 4,
  localparam int DW = ROWS * COLS,
  localparam int CW = DW + ROWS + COLS + 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          in_valid_i,
  output logic          in_ready_o,
  input  logic          mode_i,
  input  logic [CW-1:0] word_i,
  output logic          out_valid_o,
  output logic [DW-1:0] out_data_o,
  output logic [CW-1:0] out_word_o,
  output logic [1:0]    out_status_o
);
  logic [CW-1:0]   enc_word, fix_word;
  logic [ROWS-1:0] row_fail;
  logic [COLS-1:0] col_fail;
  logic            corner_fail;
  gpc_status_e     dec_status;

  gpc_encoder #(.ROWS(ROWS), .COLS(COLS)) u_enc (
    .data_i (word_i[DW-1:0]),
    .code_o (enc_word)
  );

  gpc_syndrome #(.ROWS(ROWS), .COLS(COLS)) u_syn (
    .code_i        (word_i),
    .row_fail_o    (row_fail),
    .col_fail_o    (col_fail),
    .corner_fail_o (corner_fail)
  );

  gpc_corrector #(.ROWS(ROWS), .COLS(COLS)) u_cor (
    .code_i        (word_i),
    .row_fail_i    (row_fail),
    .col_fail_i    (col_fail),
    .corner_fail_i (corner_fail),
    .code_o        (fix_word),
    .status_o      (dec_status)
  );

  assign in_ready_o = 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_valid_o <= 1'b0;
    else         out_valid_o <= in_valid_i;
  end

  logic [CW-1:0] res_word;
  logic [1:0]    res_status;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_word   <= '0;
      res_status <= ST_CLEAN;
    end else if (in_valid_i) begin
      res_word   <= mode_i ? fix_word : enc_word;
      res_status <= mode_i ? dec_status : ST_CLEAN;
    end
  end

  assign out_word_o   = res_word;
  assign out_data_o   = res_word[DW-1:0];
  assign out_status_o = res_status;

  p_valid_lat_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i |=> out_valid_o);
  p_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !in_valid_i |=> !out_valid_o);
  p_status_legal_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (out_status_o != 2'b11));
  p_enc_clean_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !mode_i) |=> (out_status_o == 2'b00));
  p_enc_data_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && !mode_i) |=> (out_data_o == $past(word_i[DW-1:0])));
endmodule

// File: tb/grid_parity_corrector_bench.sv
module grid_parity_corrector_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;
  localparam int CW = 25;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          in_valid = 1'b0;
  logic          in_ready;
  logic          mode = 1'b0;
  logic [CW-1:0] word = '0;
  logic          out_valid;
  logic [DW-1:0] out_data;
  logic [CW-1:0] out_word;
  logic [1:0]    out_status;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  grid_parity_corrector u_grid_parity_corrector (
    .clk_i(clk), .rst_ni(rst_ni), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .mode_i(mode), .word_i(word), .out_valid_o(out_valid), .out_data_o(out_data),
    .out_word_o(out_word), .out_status_o(out_status)
  );

  function automatic logic [CW-1:0] ref_enc(input logic [DW-1:0] d);
    logic [CW-1:0] w;
    w = '0;
    w[DW-1:0] = d;
    for (int r = 0; r < 4; r++) begin
      int ones = 0;
      for (int c = 0; c < 4; c++) ones += d[r*4+c];
      w[16+r] = (ones % 2 == 0);
    end
    for (int c = 0; c < 4; c++) begin
      int ones = 0;
      for (int r = 0; r < 4; r++) ones += d[r*4+c];
      w[20+c] = (ones % 2 == 0);
    end
    begin
      int ones = 0;
      for (int c = 0; c < 4; c++) ones += w[20+c];
      w[24] = (ones % 2 == 0);
    end
    return w;
  endfunction

  function automatic bit all_odd(input logic [CW-1:0] w);
    bit ok = 1'b1;
    for (int r = 0; r < 4; r++) begin
      int ones = w[16+r];
      for (int c = 0; c < 4; c++) ones += w[r*4+c];
      if (ones % 2 == 0) ok = 1'b0;
    end
    for (int c = 0; c < 4; c++) begin
      int ones = w[20+c];
      for (int r = 0; r < 4; r++) ones += w[r*4+c];
      if (ones % 2 == 0) ok = 1'b0;
    end
    begin
      int ones = w[24];
      for (int c = 0; c < 4; c++) ones += w[20+c];
      if (ones % 2 == 0) ok = 1'b0;
    end
    return ok;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic m, input logic [CW-1:0] w);
    @(negedge clk);
    in_valid = 1'b1; mode = m; word = w;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic dec_expect(input logic [CW-1:0] rx, input logic [CW-1:0] exp_w,
                            input logic [1:0] exp_st, input string tag);
    drive(1'b1, rx);
    check(out_valid == 1'b1, {tag, " valid"}, 32'(out_valid), 32'd1);
    check(out_status == exp_st, {tag, " status"}, 32'(out_status), 32'(exp_st));
    check(out_word == exp_w, {tag, " word"}, 32'(out_word), 32'(exp_w));
    check(out_data == exp_w[DW-1:0], {tag, " data"}, 32'(out_data), 32'(exp_w[DW-1:0]));
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=0", 1);
    summary();
  end

  initial begin
    logic [CW-1:0] cw;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R9 reset valid", 32'(out_valid), 32'd0);
    check(in_ready == 1'b1, "R9 ready", 32'(in_ready), 32'd1);
    rst_ni = 1'b1;

    // R1/R2/R10 encode directed
    foreach (cw[i]) ;
    drive(1'b0, 25'h0);
    check(out_word == ref_enc(16'h0), "R1 enc zero", 32'(out_word), 32'(ref_enc(16'h0)));
    check(out_status == 2'b00, "R10 enc status", 32'(out_status), 32'd0);
    drive(1'b0, {9'h1ff, 16'hffff});
    check(out_word == ref_enc(16'hffff), "R1 enc ones, upper ignored", 32'(out_word), 32'(ref_enc(16'hffff)));
    check(all_odd(out_word), "R2 odd parity ones", 32'(out_word), 32'(ref_enc(16'hffff)));
    @(negedge clk);
    check(out_valid == 1'b0, "R9 idle valid low", 32'(out_valid), 32'd0);

    cw = ref_enc(16'hA5C3);
    dec_expect(cw, cw, 2'b00, "R3 clean");
    dec_expect(cw ^ (25'd1 << 9), cw, 2'b01, "R4 data bit r2c1");
    dec_expect(cw ^ (25'd1 << 17), cw, 2'b01, "R5 row check r1");
    dec_expect(cw ^ (25'd1 << 22), cw, 2'b01, "R6 col check c2");
    dec_expect(cw ^ (25'd1 << 24), cw, 2'b01, "R7 corner");
    dec_expect(cw ^ 25'h9, cw ^ 25'h9, 2'b10, "R8 same row pair");
    dec_expect(cw ^ (25'd1 << 17) ^ (25'd1 << 24), cw ^ (25'd1 << 17) ^ (25'd1 << 24), 2'b10, "R8 row+corner");

    // back-to-back accepts
    @(negedge clk);
    in_valid = 1'b1; mode = 1'b0; word = 25'h1234;
    @(negedge clk);
    word = 25'h0F0F;
    check(out_valid == 1'b1, "R9 b2b first", 32'(out_valid), 32'd1);
    check(out_word == ref_enc(16'h1234), "R1 b2b first", 32'(out_word), 32'(ref_enc(16'h1234)));
    @(negedge clk);
    in_valid = 1'b0;
    check(out_word == ref_enc(16'h0F0F), "R1 b2b second", 32'(out_word), 32'(ref_enc(16'h0F0F)));

    for (int it = 0; it < 400; it++) begin
      logic [DW-1:0] d = 16'($urandom);
      int nerr = $urandom % 3;
      int p1 = $urandom % CW;
      int p2 = (p1 + 1 + ($urandom % (CW - 1))) % CW;
      logic [CW-1:0] rx;
      cw = ref_enc(d);
      drive(1'b0, {9'($urandom), d});
      check(out_word == cw, "R1 rand enc", 32'(out_word), 32'(cw));
      check(all_odd(out_word), "R2 rand odd", 32'(out_word), 32'(cw));
      rx = cw;
      if (nerr >= 1) rx[p1] = ~rx[p1];
      if (nerr == 2) rx[p2] = ~rx[p2];
      case (nerr)
        0: dec_expect(rx, cw, 2'b00, "R3 rand");
        1: dec_expect(rx, cw, 2'b01, p1 < 16 ? "R4 rand" : p1 < 20 ? "R5 rand" : p1 < 24 ? "R6 rand" : "R7 rand");
        default: dec_expect(rx, rx, 2'b10, "R8 rand");
      endcase
    end
    summary();
  end
endmodule